// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host drives a 2-bit address and an 8-bit data bus with separate write and read enables. Address 3 takes configuration words and multi-channel capture commands. Addresses 0, 1 and 2 are the data ports of the three channels. Every channel keeps its own access width, operating mode and BCD flag. It also has its own write and read byte sequencers, a one-shot count snapshot and a one-shot status snapshot.

The counter channels live outside this block. They present their live 16-bit count and their output level to it. In return they receive a one-cycle load strobe with the assembled 16-bit initial value, and the configured mode and BCD flag of each channel. Read data is combinational from the addressed channel's state. The sequencers advance on the clock edge that ends an enabled read.

Top module: `timer_if_top`

## Requirements
- R1: After reset every channel uses low-then-high word access, has mode 3 and BCD 0, has no pending snapshot and asserts no load strobe. Live reads of a channel return the low byte first.
- R2: A write to address 3 with channel field bits 7:6 below 3 and access field bits 5:4 nonzero sets that channel's mode from bits 3:1 and BCD from bit 0. These appear on `chanMode`/`chanBcd` one cycle later. No other channel changes.
- R3: In access 1 (low byte only), a data write loads {8'h00, byte}. In access 2 (high byte only), it loads {byte, 8'h00}. The load strobe is a one-cycle pulse one cycle after the write.
- R4: In access 3 the first data write is held and raises no strobe. The second write loads {second, first}.
- R5: A configuration word with a nonzero access field restarts both byte sequencers of that channel at the first byte. This discards any half-written word.
- R6: Access field 0 snapshots the channel's live count. Later reads return the snapshot and not the live value, in the byte order of the channel's access width. The snapshot is then released.
- R7: A count snapshot request, from either command, is ignored while an earlier snapshot of that channel is not fully read.
- R8: A write to address 3 with bits 7:6 = 3 is a capture command. Bit i+1 selects channel i. Bit 5 low captures counts and bit 4 low captures status, for all selected channels in the same cycle.
- R9: The status byte is {output level, 0, access[1:0], mode[2:0], BCD}. A new status is not captured while an earlier one is unread.
- R10: A data read returns a pending status first, then a pending count snapshot, then the live count. Each read consumes only the item it returns.
- R11: Live reads in access 3 alternate low and high bytes. Live reads in access 1 or 2 always return the same byte.
- R12: Reads from address 3 return 8'h00 and change no state.
- R13: When write and read enables are both high, the write takes effect and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0..2 data ports, 3 command port |
| wrData | input | 8 | Write data byte |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable (sequencers advance at the edge) |
| rdData | output | 8 | Read data byte for the current address |
| liveCount | input | 3x16 | Live count of each counter channel |
| outLevel | input | 3 | Output level of each counter channel |
| loadStrobe | output | 3 | One-cycle initial-value load pulse per channel |
| loadValue | output | 3x16 | Assembled initial value per channel |
| chanMode | output | 3x3 | Configured operating mode per channel |
| chanBcd | output | 3 | Configured BCD flag per channel |

## Verification
There are two same-cycle cases. The first is a capture command that asks for both count and status of all three channels in one write. Reading each channel afterwards must show the status byte, then the snapshot bytes in access order, then live data. This shows that both snapshots were taken in the same cycle and that each read consumes one item. The second is a data write and a data read raised together on a word-mode port. The write must hold its byte and later complete a load. The next read must still return the low byte, which proves that the read sequencer did not move.

// File: rtl/timer_if_pkg.sv
package timer_if_pkg;

  localparam int NUM_CH     = 3;
  localparam int BYTE_W     = 8;
  localparam int COUNT_W    = 16;
  localparam int ADDR_W     = 2;

  // access field codes
  localparam logic [1:0] ACC_SNAP = 2'd0;
  localparam logic [1:0] ACC_LO   = 2'd1;
  localparam logic [1:0] ACC_HI   = 2'd2;
  localparam logic [1:0] ACC_WORD = 2'd3;

  typedef enum logic [1:0] {
    SQ_LO  = 2'd0,
    SQ_HI  = 2'd1,
    SQ_WLO = 2'd2,
    SQ_WHI = 2'd3
  } byteSeq_t;

  // snapshot state codes equal the access code that armed them
  typedef enum logic [1:0] {
    SN_NONE = 2'd0,
    SN_LO   = 2'd1,
    SN_HI   = 2'd2,
    SN_WORD = 2'd3
  } snapState_t;

  typedef struct packed {
    logic cfgWr;
    logic cntSnap;
    logic statSnap;
    logic dataWr;
    logic dataRd;
  } chanStrobe_t;

  function automatic byteSeq_t seqFromAcc(input logic [1:0] acc);
    case (acc)
      ACC_LO:  seqFromAcc = SQ_LO;
      ACC_HI:  seqFromAcc = SQ_HI;
      default: seqFromAcc = SQ_WLO;
    endcase
  endfunction

endpackage

// File: rtl/timer_if_ctrl.sv
module timer_if_ctrl
  import timer_if_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = BYTE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DW-1:1]           cmdBits,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [NCH-1:0][DW-1:0]  chanByte,
  output chanStrobe_t [NCH-1:0]   strb,
  output logic [DW-1:0]           rdData
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = '1;
  localparam logic [1:0]        CH_CAPTURE = 2'd3;

  logic       isCmd;
  logic [1:0] chField;
  logic [1:0] accField;
  logic       isCapture;
  logic [NCH-1:0] rdVec;

  assign isCmd     = wrEn && (addr == CMD_ADDR);
  assign chField   = cmdBits[7:6];
  assign accField  = cmdBits[5:4];
  assign isCapture = (chField == CH_CAPTURE);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic chHit;
    logic capSel;
    assign chHit  = isCmd && !isCapture && (chField == 2'(i));
    assign capSel = isCmd && isCapture && cmdBits[i+1];

    assign strb[i].cfgWr    = chHit && (accField != ACC_SNAP);
    assign strb[i].cntSnap  = (chHit && (accField == ACC_SNAP)) || (capSel && !cmdBits[5]);
    assign strb[i].statSnap = capSel && !cmdBits[4];
    assign strb[i].dataWr   = wrEn && (addr == ADDR_W'(i));
    assign strb[i].dataRd   = rdEn && !wrEn && (addr == ADDR_W'(i));
    assign rdVec[i]         = strb[i].dataRd;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NCH; k++) begin
      if (addr == ADDR_W'(k)) rdData = chanByte[k];
    end
  end

  // at most one channel consumes a read per cycle (R10)
  p_read_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdVec));

  // command port reads are inert (R12)
  p_cmd_read_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == CMD_ADDR) |-> (rdData == '0 && rdVec == '0));

endmodule

// File: rtl/timer_if_chan.sv
module timer_if_chan
  import timer_if_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int CW = COUNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  chanStrobe_t   strb,
  input  logic [DW-1:0] wrData,
  input  logic [CW-1:0] liveCount,
  input  logic          outLevel,
  output logic [DW-1:0] rdByte,
  output logic          loadStrobe,
  output logic [CW-1:0] loadValue,
  output logic [2:0]    mode,
  output logic          bcd
);

  logic [1:0]    acc;
  byteSeq_t      wSeq, rSeq;
  logic [DW-1:0] holdByte;
  logic [CW-1:0] snapVal;
  snapState_t    snapSt;
  logic [DW-1:0] statByte;
  logic          statPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= ACC_WORD;
      mode       <= 3'd3;
      bcd        <= 1'b0;
      wSeq       <= SQ_WLO;
      rSeq       <= SQ_WLO;
      holdByte   <= '0;
      snapVal    <= '0;
      snapSt     <= SN_NONE;
      statByte   <= '0;
      statPend   <= 1'b0;
      loadStrobe <= 1'b0;
      loadValue  <= '0;
    end else begin
      loadStrobe <= 1'b0;

      if (strb.cfgWr) begin
        acc  <= wrData[5:4];
        mode <= wrData[3:1];
        bcd  <= wrData[0];
        wSeq <= seqFromAcc(wrData[5:4]);
        rSeq <= seqFromAcc(wrData[5:4]);
      end

      if (strb.dataWr) begin
        case (wSeq)
          SQ_LO: begin
            loadValue  <= {{(CW-DW){1'b0}}, wrData};
            loadStrobe <= 1'b1;
          end
          SQ_HI: begin
            loadValue  <= {wrData, {(CW-DW){1'b0}}};
            loadStrobe <= 1'b1;
          end
          SQ_WLO: begin
            holdByte <= wrData;
            wSeq     <= SQ_WHI;
          end
          default: begin
            loadValue  <= {wrData, holdByte};
            loadStrobe <= 1'b1;
            wSeq       <= SQ_WLO;
          end
        endcase
      end

      if (strb.cntSnap && snapSt == SN_NONE) begin
        snapVal <= liveCount;
        snapSt  <= snapState_t'(acc);
      end

      if (strb.statSnap && !statPend) begin
        statByte <= {outLevel, 1'b0, acc, mode, bcd};
        statPend <= 1'b1;
      end

      if (strb.dataRd) begin
        if (statPend) begin
          statPend <= 1'b0;
        end else if (snapSt != SN_NONE) begin
          snapSt <= (snapSt == SN_WORD) ? SN_HI : SN_NONE;
        end else begin
          case (rSeq)
            SQ_WLO:  rSeq <= SQ_WHI;
            SQ_WHI:  rSeq <= SQ_WLO;
            default: rSeq <= rSeq;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (statPend)
      rdByte = statByte;
    else if (snapSt == SN_LO || snapSt == SN_WORD)
      rdByte = snapVal[DW-1:0];
    else if (snapSt == SN_HI)
      rdByte = snapVal[CW-1:CW-DW];
    else if (rSeq == SQ_HI || rSeq == SQ_WHI)
      rdByte = liveCount[CW-1:CW-DW];
    else
      rdByte = liveCount[DW-1:0];
  end

  // a load pulse only follows a data write (R3)
  p_load_after_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> $past(strb.dataWr));

  // the first byte of a word never loads (R4)
  p_word_first_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && wSeq == SQ_WLO) |=> !loadStrobe);

  // mode changes only by a configuration word (R2)
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgWr |=> $stable(mode));

  // a pending count snapshot is frozen (R7)
  p_snap_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (snapSt != SN_NONE && !strb.dataRd) |=> $stable(snapVal));

  // a pending status stays until read (R9)
  p_status_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statPend && !strb.dataRd) |=> (statPend && $stable(statByte)));

endmodule

// File: rtl/timer_if_datapath.sv
module timer_if_datapath
  import timer_if_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = BYTE_W,
  parameter int CW  = COUNT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chanStrobe_t [NCH-1:0]   strb,
  input  logic [DW-1:0]           wrData,
  input  logic [NCH-1:0][CW-1:0]  liveCount,
  input  logic [NCH-1:0]          outLevel,
  output logic [NCH-1:0][DW-1:0]  chanByte,
  output logic [NCH-1:0]          loadStrobe,
  output logic [NCH-1:0][CW-1:0]  loadValue,
  output logic [NCH-1:0][2:0]     chanMode,
  output logic [NCH-1:0]          chanBcd
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    timer_if_chan #(.DW(DW), .CW(CW)) u_chan (
      .clk        (clk),
      .rstN       (rstN),
      .strb       (strb[i]),
      .wrData     (wrData),
      .liveCount  (liveCount[i]),
      .outLevel   (outLevel[i]),
      .rdByte     (chanByte[i]),
      .loadStrobe (loadStrobe[i]),
      .loadValue  (loadValue[i]),
      .mode       (chanMode[i]),
      .bcd        (chanBcd[i])
    );
  end

endmodule

// File: rtl/timer_if_top.sv
module timer_if_top
  import timer_if_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = BYTE_W,
  parameter int CW  = COUNT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wrData,
  input  logic                   wrEn,
  input  logic                   rdEn,
  output logic [DW-1:0]          rdData,
  input  logic [NCH-1:0][CW-1:0] liveCount,
  input  logic [NCH-1:0]         outLevel,
  output logic [NCH-1:0]         loadStrobe,
  output logic [NCH-1:0][CW-1:0] loadValue,
  output logic [NCH-1:0][2:0]    chanMode,
  output logic [NCH-1:0]         chanBcd
);

  chanStrobe_t [NCH-1:0]  strb;
  logic [NCH-1:0][DW-1:0] chanByte;

  timer_if_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .cmdBits  (wrData[DW-1:1]),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .chanByte (chanByte),
    .strb     (strb),
    .rdData   (rdData)
  );

  timer_if_datapath #(.NCH(NCH), .DW(DW), .CW(CW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .liveCount  (liveCount),
    .outLevel   (outLevel),
    .chanByte   (chanByte),
    .loadStrobe (loadStrobe),
    .loadValue  (loadValue),
    .chanMode   (chanMode),
    .chanBcd    (chanBcd)
  );

endmodule

// File: tb/timer_if_top_bench.sv
module timer_if_top_bench;

  localparam int NCH = 3;
  localparam int NVEC = 20;
  localparam logic [1:0] OP_WR = 2'd0;  // write, expect no load
  localparam logic [1:0] OP_WL = 2'd1;  // write, expect load of exp
  localparam logic [1:0] OP_RD = 2'd2;  // read, expect rdData == exp[7:0]

  // {op, addr, data, exp, req}
  localparam logic [31:0] VEC [NVEC] = '{
    {OP_RD, 2'd0, 8'h00, 16'h0034, 4'd11},  // R11 word live low
    {OP_RD, 2'd0, 8'h00, 16'h0012, 4'd11},  // R11 then high
    {OP_RD, 2'd0, 8'h00, 16'h0034, 4'd1},   // R1 reset order resumes at low
    {OP_WR, 2'd3, 8'h54, 16'h0000, 4'd2},   // R2 ch1 low-only, mode 2
    {OP_WL, 2'd1, 8'h77, 16'h0077, 4'd3},   // R3 low-only load
    {OP_RD, 2'd1, 8'h00, 16'h00CD, 4'd11},  // R11 low-only repeats
    {OP_RD, 2'd1, 8'h00, 16'h00CD, 4'd11},
    {OP_WR, 2'd3, 8'hA1, 16'h0000, 4'd2},   // R2 ch2 high-only, mode 0, bcd
    {OP_WL, 2'd2, 8'h9C, 16'h9C00, 4'd3},   // R3 high-only load
    {OP_RD, 2'd2, 8'h00, 16'h005A, 4'd11},
    {OP_WR, 2'd3, 8'h38, 16'h0000, 4'd5},   // R5 ch0 word, mode 4
    {OP_WR, 2'd0, 8'h11, 16'h0000, 4'd4},   // R4 first byte held
    {OP_WL, 2'd0, 8'h22, 16'h2211, 4'd4},   // R4 word load
    {OP_WR, 2'd3, 8'h00, 16'h0000, 4'd6},   // R6 snapshot ch0
    {OP_RD, 2'd3, 8'h00, 16'h0000, 4'd12},  // R12 command port reads zero
    {OP_RD, 2'd0, 8'h00, 16'h0034, 4'd6},
    {OP_WR, 2'd3, 8'h00, 16'h0000, 4'd7},   // R7 repeat request mid-read
    {OP_RD, 2'd0, 8'h00, 16'h0012, 4'd7},
    {OP_RD, 2'd0, 8'h00, 16'h0034, 4'd10},  // R10 live after snapshot
    {OP_RD, 2'd0, 8'h00, 16'h0012, 4'd11}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic [NCH-1:0][15:0] liveCount;
  logic [NCH-1:0] outLevel = 3'b101;
  logic [NCH-1:0] loadStrobe;
  logic [NCH-1:0][15:0] loadValue;
  logic [NCH-1:0][2:0] chanMode;
  logic [NCH-1:0] chanBcd;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  timer_if_top u_timer_if_top (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .liveCount(liveCount), .outLevel(outLevel),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .chanMode(chanMode),
    .chanBcd(chanBcd)
  );

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busOp(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d,
                       input logic [15:0] exp, input int req, input logic both);
    logic [7:0] got;
    @(negedge clk);
    addr = a; wrData = d;
    wrEn = (op != OP_RD) || both;
    rdEn = (op == OP_RD) || both;
    #2 got = rdData;
    @(posedge clk);
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
    if (op == OP_RD) check(req, {8'h00, got}, exp);
    else if (op == OP_WL) begin
      check(req, {13'd0, loadStrobe}, 16'(3'b001 << a));
      check(req, loadValue[a], exp);
    end else check(req, {13'd0, loadStrobe}, 16'd0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input int req);
    busOp(OP_RD, a, 8'h00, {8'h00, e}, req, 1'b0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input int req);
    busOp(OP_WR, a, d, 16'h0000, req, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    liveCount[0] = 16'h1234;
    liveCount[1] = 16'hABCD;
    liveCount[2] = 16'h5A0F;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state at the ports
    check(1, {13'd0, loadStrobe}, 16'd0);
    check(1, {7'd0, chanMode}, {7'd0, 3'd3, 3'd3, 3'd3});
    check(1, {13'd0, chanBcd}, 16'd0);

    for (int v = 0; v < NVEC; v++) begin
      busOp(VEC[v][31:30], VEC[v][29:28], VEC[v][27:20], VEC[v][19:4],
            int'(VEC[v][3:0]), 1'b0);
    end

    // R2 configured fields per channel
    check(2, {7'd0, chanMode}, {7'd0, 3'd0, 3'd2, 3'd4});
    check(2, {13'd0, chanBcd}, 16'b100);

    // R6 snapshot differs from the later live value (ch1 low-only)
    wr(2'd3, 8'h40, 6);
    liveCount[1] = 16'h4321;
    rd(2'd1, 8'hCD, 6);
    rd(2'd1, 8'h21, 6);

    // R7 a second request is ignored until the snapshot is read out
    wr(2'd3, 8'h00, 7);
    liveCount[0] = 16'hBEEF;
    rd(2'd0, 8'h34, 7);
    wr(2'd3, 8'h00, 7);
    rd(2'd0, 8'h12, 7);
    wr(2'd3, 8'h00, 7);
    rd(2'd0, 8'hEF, 7);
    rd(2'd0, 8'hBE, 7);

    // R5 configuration drops a half-written word
    wr(2'd0, 8'h55, 5);
    wr(2'd3, 8'h38, 5);
    wr(2'd0, 8'h66, 5);
    busOp(OP_WL, 2'd0, 8'h77, 16'h7766, 5, 1'b0);

    // R8 R9 R10 capture count and status of all channels at once
    wr(2'd3, 8'hCE, 8);
    rd(2'd0, 8'hB8, 9);
    rd(2'd0, 8'hEF, 10);
    rd(2'd0, 8'hBE, 10);
    rd(2'd1, 8'h14, 9);
    rd(2'd1, 8'h21, 10);
    rd(2'd2, 8'hA1, 9);
    rd(2'd2, 8'h5A, 10);

    // R9 unread status is not recaptured
    wr(2'd3, 8'hE4, 9);
    outLevel = 3'b111;
    wr(2'd3, 8'hE4, 9);
    rd(2'd1, 8'h14, 9);
    rd(2'd1, 8'h21, 9);

    // R8 count-only capture of ch2
    wr(2'd3, 8'hD8, 8);
    liveCount[2] = 16'h7700;
    rd(2'd2, 8'h5A, 8);
    rd(2'd2, 8'h77, 8);

    // R12 command-port read leaves ch0 sequencing untouched
    wr(2'd3, 8'h38, 12);
    rd(2'd3, 8'h00, 12);
    rd(2'd0, 8'hEF, 12);
    rd(2'd0, 8'hBE, 12);

    // R13 write and read together: write acts, read does not advance
    busOp(OP_WR, 2'd0, 8'h44, 16'h0000, 13, 1'b1);
    rd(2'd0, 8'hEF, 13);
    busOp(OP_WL, 2'd0, 8'h55, 16'h5544, 13, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule